// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical four-bit stages. All stages share one clock. Each stage can be preset from a parallel data word while its load strobe (active low) is asserted. Counting needs two enables: a parallel enable that every stage sees, and a trickle enable. The trickle enable passes from stage to stage through each stage's terminal-count output. A stage advances only when its trickle input is high and every stage below it holds all ones, so the chain behaves as one wide binary counter that steps on a single clock edge.

An active-low clear has top priority, then load, then count, then hold. A build-time parameter makes the clear either asynchronous, acting the moment it falls, or synchronous, acting at the next rising edge. The synchronous build can shorten its cycle: external logic decodes a chosen count and drives the clear from that decode. The final terminal-count output is combinational in the trickle enable, so a further counter outside the block can take it as its own trickle input.

Top module: `preset_cascade_ctr`

## Requirements
- R1: With CLEAR_ASYNC=1, a low `clr_n` forces `q` to zero without waiting for a clock edge, whatever the load strobe and enables are.
- R2: With CLEAR_ASYNC=0, a low `clr_n` leaves `q` unchanged until the next rising edge. At that edge `q` becomes zero, even if `load_n` is low and both enables are high.
- R3: With `clr_n` high and `load_n` low, a rising edge copies `din` into `q`, whatever the levels of `en_par` and `en_trk`. Stage k takes bits [4k+3:4k].
- R4: With `clr_n` and `load_n` high and both `en_par` and `en_trk` high, a rising edge adds one to `q`, read as a single unsigned binary number.
- R5: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R6: `tc` is high exactly when `en_trk` is high and every bit of `q` is one. It follows a change of `en_trk` within the same cycle, with no clock edge needed.
- R7: A count from all ones wraps `q` to zero, and `tc` goes low at that same edge.
- R8: Stage k+1 takes its trickle input from the terminal count of stage k. Counting therefore carries across every four-bit boundary, and a three-stage chain passes through all 4096 values in order.
- R9: In the synchronous build, driving `clr_n` from a decode of the count value 6 gives the repeating sequence 0, 1, ..., 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous by CLEAR_ASYNC |
| load_n | input | 1 | Active-low parallel preset strobe |
| en_par | input | 1 | Parallel count enable, fed to every stage |
| en_trk | input | 1 | Trickle count enable into the lowest stage |
| din | input | STAGES*STAGE_W | Preset data word |
| q | output | STAGES*STAGE_W | Counter value |
| tc | output | 1 | Terminal count of the top stage |

## Verification
Most results are registered: a load, count, hold or synchronous clear shows up on `q` after exactly one rising edge. The bench changes inputs just after a falling edge and compares `q` at the next falling edge, which is one full register stage later. Two results need no edge at all, the asynchronous clear and `tc`. The bench checks these about 2 ns after it changes the inputs, still ahead of the next rising edge. In that same window it also checks that the synchronous build has not yet cleared.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Operation chosen for a stage on the coming edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_op_dec.sv
module ctr_op_dec
    import ctr_pkg::*;
(
    input  logic    clr_sync_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output ctr_op_e op
);

    always_comb begin
        if (!clr_sync_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
    import ctr_pkg::*;
#(
    parameter int STAGE_W     = 4,
    parameter bit CLEAR_ASYNC = 1'b1
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_par,
    input  logic               trk_in,
    input  logic [STAGE_W-1:0] din,
    output logic [STAGE_W-1:0] cnt,
    output logic               trk_out
);

    localparam logic [STAGE_W-1:0] ONE  = STAGE_W'(1);
    localparam logic [STAGE_W-1:0] FULL = {STAGE_W{1'b1}};

    typedef struct packed {
        logic [STAGE_W-1:0] cnt;
    } stage_st_t;

    stage_st_t st_d, st_q;
    ctr_op_e   op;
    logic      clr_sync_n;

    // The asynchronous build clears in the register itself, so the
    // decoder then never sees a clear.
    assign clr_sync_n = CLEAR_ASYNC ? 1'b1 : clr_n;

    ctr_op_dec u_dec (
        .clr_sync_n (clr_sync_n),
        .load_n     (load_n),
        .en_par     (en_par),
        .en_trk     (trk_in),
        .op         (op)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = st_q.cnt + ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (CLEAR_ASYNC) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            p_async_clr_r1: assert property (@(posedge clk)
                !clr_n |-> cnt == '0);
        end else begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            p_sync_clr_r2: assert property (@(posedge clk)
                !clr_n |=> cnt == '0);
        end
    endgenerate

    assign cnt     = st_q.cnt;
    assign trk_out = trk_in & (st_q.cnt == FULL);

    p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> cnt == $past(din));

    p_count_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && trk_in) |=> cnt == $past(cnt) + ONE);

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && trk_in)) |=> $stable(cnt));

endmodule

// File: rtl/preset_cascade_ctr.sv
module preset_cascade_ctr #(
    parameter int STAGE_W     = 4,
    parameter int STAGES      = 3,
    parameter bit CLEAR_ASYNC = 1'b1
) (
    input  logic                       clk,
    input  logic                       clr_n,
    input  logic                       load_n,
    input  logic                       en_par,
    input  logic                       en_trk,
    input  logic [STAGES*STAGE_W-1:0]  din,
    output logic [STAGES*STAGE_W-1:0]  q,
    output logic                       tc
);

    localparam int TOT_W = STAGES * STAGE_W;
    localparam logic [TOT_W-1:0] ONE_W = TOT_W'(1);

    // trk[k] enters stage k; trk[STAGES] leaves the top stage.
    logic [STAGES:0] trk;

    assign trk[0] = en_trk;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            ctr_stage #(
                .STAGE_W     (STAGE_W),
                .CLEAR_ASYNC (CLEAR_ASYNC)
            ) u_stage (
                .clk     (clk),
                .clr_n   (clr_n),
                .load_n  (load_n),
                .en_par  (en_par),
                .trk_in  (trk[k]),
                .din     (din[k*STAGE_W +: STAGE_W]),
                .cnt     (q[k*STAGE_W +: STAGE_W]),
                .trk_out (trk[k+1])
            );
        end
    endgenerate

    assign tc = trk[STAGES];

    p_tc_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
        tc == (en_trk && (&q)));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && (&q)) |=> (q == '0) && !tc);

    p_chain_step_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> q == $past(q) + ONE_W);

endmodule

// File: tb/preset_cascade_ctr_tb_top.sv
module preset_cascade_ctr_tb_top;

    localparam int SW = 4;
    localparam int NS = 3;
    localparam int NB = SW * NS;
    localparam logic [NB-1:0] MAXV = {NB{1'b1}};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [NB-1:0] din = '0;
    logic [NB-1:0] qa, qs;
    logic          tca, tcs;
    logic [SW-1:0] qm;
    logic          tcm, mod_on = 1'b0, clr_m;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [NB-1:0] ma = '0, ms = '0;

    preset_cascade_ctr #(.STAGE_W(SW), .STAGES(NS), .CLEAR_ASYNC(1'b1)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .q(qa), .tc(tca));

    preset_cascade_ctr #(.STAGE_W(SW), .STAGES(NS), .CLEAR_ASYNC(1'b0)) dut_s (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .q(qs), .tc(tcs));

    // R9: the clear of a single synchronous stage is taken from a decode of 6.
    assign clr_m = mod_on ? (qm != 4'd6) : clr_n;

    preset_cascade_ctr #(.STAGE_W(SW), .STAGES(1), .CLEAR_ASYNC(1'b0)) dut_m (
        .clk(clk), .clr_n(clr_m), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din[SW-1:0]), .q(qm), .tc(tcm));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NB-1:0] nxt(input logic [NB-1:0] cur, input logic c,
        input logic l, input logic p, input logic t, input logic [NB-1:0] d);
        if (!c)         return '0;
        else if (!l)    return d;
        else if (p & t) return cur + NB'(1);
        else            return cur;
    endfunction

    // Called just after a falling edge: apply inputs, check combinational
    // results, pass one rising edge, check registered results.
    task automatic cyc(input logic c, input logic l, input logic p, input logic t,
                       input logic [NB-1:0] d, input string tag);
        clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
        #2;
        if (!c) begin
            ma = '0;
            chk(qa == '0, "R1 async clear immediate", 32'(qa), 0);
            chk(qs == ms, "R2 sync clear waits for edge", 32'(qs), 32'(ms));
        end
        chk(tca == (t && ma == MAXV), {"R6 tc async build ", tag}, 32'(tca),
            32'(t && ma == MAXV));
        chk(tcs == (t && ms == MAXV), {"R6 tc sync build ", tag}, 32'(tcs),
            32'(t && ms == MAXV));
        ma = nxt(ma, c, l, p, t, d);
        ms = nxt(ms, c, l, p, t, d);
        @(posedge clk);
        @(negedge clk);
        chk(qa == ma, {tag, " async build"}, 32'(qa), 32'(ma));
        chk(qs == ms, {tag, " sync build"}, 32'(qs), 32'(ms));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        chk(qa == '0, "R1 reset state async", 32'(qa), 0);
        chk(qs == '0, "R2 reset state sync", 32'(qs), 0);

        // R8 / R4 / R7: full sweep of the chain and its wrap.
        cyc(1, 0, 0, 0, '0, "R3 preset zero");
        for (int i = 0; i < 4097; i++) cyc(1, 1, 1, 1, '0, "R8 chain count");
        chk(qa == 12'd1, "R7 wrapped past zero", 32'(qa), 1);

        // R5: hold with either enable low, and tc gating.
        cyc(1, 0, 0, 0, MAXV, "R3 load all ones");
        cyc(1, 1, 1, 0, '0, "R5 hold trickle low");
        cyc(1, 1, 0, 1, '0, "R5 hold parallel low");
        cyc(1, 1, 0, 0, '0, "R5 hold both low");
        cyc(1, 1, 1, 1, '0, "R7 wrap to zero");
        chk(tca == 1'b0 && tcs == 1'b0, "R7 tc low after wrap", 32'(tca | tcs), 0);

        // R6: tc follows en_trk with no edge.
        cyc(1, 0, 1, 1, MAXV, "R3 load max with enables high");
        en_trk = 1'b0; en_par = 1'b0; load_n = 1'b1; #2;
        chk(tca == 1'b0, "R6 tc drops with trickle", 32'(tca), 0);
        en_trk = 1'b1; #2;
        chk(tca == 1'b1, "R6 tc rises with trickle", 32'(tca), 1);
        chk(tcs == 1'b1, "R6 tc rises with trickle sync", 32'(tcs), 1);
        @(negedge clk);

        // R3: load under each enable pattern, carry at each boundary.
        cyc(1, 0, 0, 1, 12'h00F, "R3 load enables 01");
        cyc(1, 1, 1, 1, '0, "R8 carry into stage 1");
        cyc(1, 0, 1, 0, 12'h0FF, "R3 load enables 10");
        cyc(1, 1, 1, 1, '0, "R8 carry into stage 2");
        cyc(1, 0, 1, 1, 12'hA5C, "R3 load enables 11");

        // R1 / R2: clear beats load and count.
        cyc(0, 0, 1, 1, 12'h123, "R2 clear over load");
        cyc(1, 0, 1, 1, 12'h7FE, "R3 reload");
        cyc(0, 1, 1, 1, '0, "R2 clear over count");

        // Pseudo-random mix against the priority model.
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[3:0] != 4'd0, lf[7:5] != 3'd0, lf[8] | lf[9], lf[10] | lf[11],
                {lf[11:0] ^ {lf[3:0], lf[15:8]}}, "R4 random mix");
        end

        // R9: modulo-7 by decoding 6 into the synchronous clear.
        cyc(0, 1, 0, 0, '0, "R2 clear before modulo");
        clr_n = 1'b1; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
        mod_on = 1'b1;
        for (int i = 0; i < 22; i++) begin
            #2;
            chk(qm == 4'(i % 7), "R9 modulo seven", 32'(qm), 32'(i % 7));
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule